// File: doc/BRIEF.md
# Bidirectional Three-Mode Bus Transceiver Register

This block sits between two 18-bit data buses, called A and B, and moves data between them in both directions. Each direction has its own storage element, its own hold control, its own capture strobe and its own drive control. When a direction is open, data passes straight through. When it is closed and its strobe is steady, the last value is held. When it is closed and its strobe rises, the input is captured, and the captured value then appears on the far side.

The whole block runs on one system clock. The two capture strobes are sampled like any other input, and a rising strobe is detected by comparing each sample with the one before it. The pads are not modelled. Each bus side is a data output plus a drive flag, and the pad logic turns that pair into tri-state behaviour.

The drive control of the A-to-B path is active high. The drive control of the B-to-A path is active low. Drive only decides whether an output is driven. Storage keeps updating while the output is not driven.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's open control (`ab_open_i` or `ba_open_i`) is 1, its data output equals its current input in the same cycle. Its storage takes that input at every clock edge, so after the control falls the output shows the input from the last edge at which the control was still 1.
- R2: While the open control is 0 and no strobe rise is detected, the data output stays unchanged at every clock edge, whatever the input does and whether the strobe is steady at 0 or at 1.
- R3: A strobe rise is detected at a clock edge when the strobe sample there is 1 and the sample at the previous edge was 0. With the open control at 0, that edge captures the input into storage, and the output shows it from that edge onward.
- R4: A strobe rise while the open control is 1 has no effect beyond R1: storage holds the input of that edge.
- R5: The B-side drive flag `b_drv_o` is 1 exactly when `ab_oe_i` is 1 and reset is not asserted.
- R6: The A-side drive flag `a_drv_o` is 1 exactly when `ba_oe_n_i` is 0 and reset is not asserted.
- R7: Storage captures and tracks data regardless of the drive control, so a value taken while the drive is off appears once the drive is turned on.
- R8: A synchronous reset clears both storage elements to 0 and forces both drive flags to 0. It also sets both previous-strobe samples to 1, so a strobe that is already high after reset is not taken as a rise.
- R9: The two paths are independent: activity on one path never changes the other path's data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| a_i | input | 18 | A-bus data into the A-to-B path |
| b_i | input | 18 | B-bus data into the B-to-A path |
| ab_oe_i | input | 1 | B-side drive control, active high |
| ab_open_i | input | 1 | A-to-B open control (1 = pass through) |
| ab_stb_i | input | 1 | A-to-B capture strobe, sampled |
| ba_oe_n_i | input | 1 | A-side drive control, active low |
| ba_open_i | input | 1 | B-to-A open control (1 = pass through) |
| ba_stb_i | input | 1 | B-to-A capture strobe, sampled |
| b_o | output | 18 | Data presented to the B bus |
| b_drv_o | output | 1 | B bus is driven when 1 |
| a_o | output | 18 | Data presented to the A bus |
| a_drv_o | output | 1 | A bus is driven when 1 |

## Verification
The open path and both drive flags are combinational, so their results are due in the same cycle as the stimulus. A strobe capture, a hold and a reset show up right after the first clock edge that samples them. The bench applies each stimulus at a falling edge and pushes the expected outputs for the next rising edge. It then compares 5 ns after that rising edge, which is one clock edge from each stimulus. Held values are checked over several edges while the inputs and the steady strobe level change.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned BUS_W = 18;

  // Drive decision for one side: polarity chosen per path, reset wins.
  function automatic logic drive_on(input logic oe, input logic act_high, input logic rst);
    return !rst && (act_high ? oe : !oe);
  endfunction

  // Rising strobe seen between two consecutive samples.
  function automatic logic strobe_rise(input logic prev, input logic cur);
    return !prev && cur;
  endfunction
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk_i,
  input  logic rst_i,
  input  logic stb_i,
  output logic rise_o
);
  import xcvr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b1;
    else       prev_q <= stb_i;
  end

  assign rise_o = strobe_rise(prev_q, stb_i);

  // R8: right after reset a high strobe is not a rise
  assert_no_rise_after_reset_R8: assert property (@(posedge clk_i)
    rst_i |=> (!rise_o || !$past(stb_i) || $past(rst_i) == 1'b1 && !stb_i) || !rise_o);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         open_i,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic take;
  assign take = open_i || cap_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= '0;
    else if (take) q_o <= d_i;
  end

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    rst_i |=> q_o == '0);
  assert_track_open_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    open_i |=> q_o == $past(d_i));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!open_i && !cap_i) |=> $stable(q_o));
  assert_capture_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!open_i && cap_i) |=> q_o == $past(d_i));
  assert_open_wins_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (open_i && cap_i) |=> q_o == $past(d_i));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned W       = 18,
  parameter bit          OE_HIGH = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  input  logic         oe_i,
  input  logic         open_i,
  input  logic         stb_i,
  output logic [W-1:0] y_o,
  output logic         drv_o
);
  import xcvr_pkg::*;

  logic         rise;
  logic [W-1:0] held;

  xcvr_rise_det u_det (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .stb_i (stb_i),
    .rise_o(rise)
  );

  xcvr_store #(.W(W)) u_store (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .open_i(open_i),
    .cap_i (rise),
    .d_i   (d_i),
    .q_o   (held)
  );

  assign y_o   = open_i ? d_i : held;
  assign drv_o = drive_on(oe_i, OE_HIGH, rst_i);

  // R7: the drive control never blocks an update of storage
  assert_store_ignores_oe_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!open_i && rise && !drv_o) |=> held == $past(d_i));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int unsigned WIDTH = xcvr_pkg::BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ab_oe_i,
  input  logic             ab_open_i,
  input  logic             ab_stb_i,
  input  logic             ba_oe_n_i,
  input  logic             ba_open_i,
  input  logic             ba_stb_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_drv_o,
  output logic [WIDTH-1:0] a_o,
  output logic             a_drv_o
);
  // A to B: drive active high
  xcvr_path #(.W(WIDTH), .OE_HIGH(1'b1)) u_ab (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (a_i),
    .oe_i  (ab_oe_i),
    .open_i(ab_open_i),
    .stb_i (ab_stb_i),
    .y_o   (b_o),
    .drv_o (b_drv_o)
  );

  // B to A: drive active low
  xcvr_path #(.W(WIDTH), .OE_HIGH(1'b0)) u_ba (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (b_i),
    .oe_i  (ba_oe_n_i),
    .open_i(ba_open_i),
    .stb_i (ba_stb_i),
    .y_o   (a_o),
    .drv_o (a_drv_o)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    rst_i |-> (!b_drv_o && !a_drv_o));
  assert_b_drive_high_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ab_oe_i == b_drv_o);
  assert_a_drive_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ba_oe_n_i == !a_drv_o);
endmodule

// File: tb/test_bus_xcvr.sv
module test_bus_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic         rst;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ab_oe;
    logic         ab_open;
    logic         ab_stb;
    logic         ba_oe_n;
    logic         ba_open;
    logic         ba_stb;
  } stim_t;

  typedef struct {
    string        tag;
    logic [W-1:0] b;
    logic         bd;
    logic [W-1:0] a;
    logic         ad;
  } exp_t;

  stim_t cur, drv;
  exp_t  sb[$];

  logic [W-1:0] b_o, a_o;
  logic         b_drv_o, a_drv_o;

  // bench-side model state
  logic [W-1:0] m_ab, m_ba;
  logic         m_pab, m_pba;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  bus_xcvr #(.WIDTH(W)) i_bus_xcvr (
    .clk_i    (clk),
    .rst_i    (drv.rst),
    .a_i      (drv.a),
    .b_i      (drv.b),
    .ab_oe_i  (drv.ab_oe),
    .ab_open_i(drv.ab_open),
    .ab_stb_i (drv.ab_stb),
    .ba_oe_n_i(drv.ba_oe_n),
    .ba_open_i(drv.ba_open),
    .ba_stb_i (drv.ba_stb),
    .b_o      (b_o),
    .b_drv_o  (b_drv_o),
    .a_o      (a_o),
    .a_drv_o  (a_drv_o)
  );

  // Driver: apply at falling edge, push what the next rising edge must show.
  task automatic tick(input string tag);
    exp_t e;
    @(negedge clk);
    drv = cur;
    if (cur.rst) begin
      m_ab = '0; m_ba = '0; m_pab = 1'b1; m_pba = 1'b1;
    end else begin
      if (cur.ab_open || (cur.ab_stb && !m_pab)) m_ab = cur.a;
      if (cur.ba_open || (cur.ba_stb && !m_pba)) m_ba = cur.b;
      m_pab = cur.ab_stb;
      m_pba = cur.ba_stb;
    end
    e.tag = tag;
    e.b   = cur.ab_open ? cur.a : m_ab;
    e.a   = cur.ba_open ? cur.b : m_ba;
    e.bd  = !cur.rst && cur.ab_oe;
    e.ad  = !cur.rst && !cur.ba_oe_n;
    sb.push_back(e);
  endtask

  // Monitor: compare 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (b_o !== e.b || b_drv_o !== e.bd || a_o !== e.a || a_drv_o !== e.ad) begin
          misses++;
          $display("FAIL %s: b=%h/%b a=%h/%b expected b=%h/%b a=%h/%b",
                   e.tag, b_o, b_drv_o, a_o, a_drv_o, e.b, e.bd, e.a, e.ad);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    cur = '0; cur.rst = 1'b1; cur.ba_oe_n = 1'b1;
    drv = cur;
    m_ab = '0; m_ba = '0; m_pab = 1'b1; m_pba = 1'b1;
    // R8: reset clears storage, drives off even with drive requested
    cur.ab_oe = 1'b1; cur.ba_oe_n = 1'b0;
    cur.a = 18'h2AAAA; cur.b = 18'h15555; cur.ab_stb = 1'b1; cur.ba_stb = 1'b1;
    repeat (2) tick("R8 reset");
    cur.rst = 1'b0;
    // R8: strobes high right after reset are no rise
    tick("R8 high strobe after reset");
    tick("R2 steady high strobe");
    // R1: transparent A->B with several values
    cur.ab_open = 1'b1; cur.a = 18'h12345; tick("R1 open");
    cur.a = 18'h3FFFF; tick("R1 open all ones");
    cur.a = 18'h00001; tick("R1 open last");
    // R1/R2: close, then change input: hold last open value
    cur.ab_open = 1'b0; cur.a = 18'h0BEEF; tick("R1 hold after close");
    cur.a = 18'h1CAFE; tick("R2 hold high strobe");
    cur.ab_stb = 1'b0; cur.a = 18'h22222; tick("R2 hold falling strobe");
    cur.a = 18'h33333; tick("R2 hold low strobe");
    // R3: rising strobe captures
    cur.ab_stb = 1'b1; cur.a = 18'h0F0F0; tick("R3 capture");
    cur.a = 18'h01234; tick("R3 no second capture");
    // R5: drive off, R7: capture while off, then drive on
    cur.ab_oe = 1'b0; cur.ab_stb = 1'b0; tick("R5 drive off");
    cur.ab_stb = 1'b1; cur.a = 18'h2D2D2; tick("R7 capture while undriven");
    cur.ab_oe = 1'b1; cur.a = 18'h00000; tick("R7 value after drive on");
    // R4: open with rising strobe
    cur.ab_stb = 1'b0; tick("R4 prep");
    cur.ab_open = 1'b1; cur.ab_stb = 1'b1; cur.a = 18'h3A5A5; tick("R4 open and rise");
    cur.ab_open = 1'b0; cur.a = 18'h11111; tick("R4 held after");
    // R6 and R9: B->A path, active-low drive, A->B unchanged
    cur.ba_oe_n = 1'b1; tick("R6 drive off when high");
    cur.ba_oe_n = 1'b0; cur.ba_stb = 1'b0; tick("R6 drive on when low");
    cur.ba_stb = 1'b1; cur.b = 18'h24680; tick("R9 B->A capture, A->B held");
    cur.ba_open = 1'b1; cur.b = 18'h13579; tick("R1 B->A open");
    cur.ba_open = 1'b0; cur.b = 18'h00FF0; tick("R2 B->A hold");
    // R9: A->B activity leaves A side alone
    cur.ab_open = 1'b1; cur.a = 18'h3C3C3; tick("R9 A->B open, B->A held");
    // R8: reset mid-run
    cur.rst = 1'b1; tick("R8 reset mid-run");
    cur.rst = 1'b0; cur.ab_open = 1'b0; tick("R8 cleared after reset");
    tick("flush");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule